// File: doc/BRIEF.md
# Integer Execution Unit with Leading-Bit Counting

This block is the 32-bit integer datapath of a small load/store RISC core. Each cycle it takes two register operands, a 16-bit immediate, a 5-bit shift distance and a 5-bit operation code. It registers a 32-bit result, a signed-overflow flag and a write-enable. Decode, the register file and exception handling sit around it: the overflow flag is only reported, and the write-enable tells the writeback stage whether to commit the result.

A small front stage picks the second operand. It is either the second register or the immediate, sign- or zero-extended according to the operation. The unit covers addition and subtraction in trapping and non-trapping forms, the four bitwise logic functions, signed and unsigned set-less-than, logical and arithmetic shifts by a fixed or register distance, upper-immediate load, leading-zero and leading-one counts, and conditional moves.

All outputs are registered, so a result appears one clock after its inputs are presented. Reset is synchronous and active high.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `result_o`, `ovf_o` and `wr_en_o` become 0 at that edge. Otherwise the outputs after each rising edge reflect the inputs sampled at that edge, one cycle of latency.
- R2: Codes ADD=0, ADDU=1, ADDI=21 and ADDIU=22 give the sum modulo 2^32. ADDI and ADDIU use the immediate sign-extended from bit 15. Codes SUB=2 and SUBU=3 give `src_a_i - src_b_i` modulo 2^32.
- R3: `ovf_o` is 1 for ADD, ADDI and SUB exactly when the two's-complement result does not fit in 32 bits.
- R4: `ovf_o` is 0 for every code other than ADD, ADDI and SUB, including ADDU, ADDIU and SUBU.
- R5: AND=4, OR=5, XOR=6 and NOR=7 apply the bitwise function to the two registers; NOR is the complement of OR. ANDI=25, ORI=26 and XORI=27 use the immediate zero-extended to 32 bits.
- R6: SLT=8 and SLTI=23 compare as signed; SLTU=9 and SLTIU=24 compare as unsigned. The result is 1 when operand A is below operand B and 0 otherwise. Both immediate forms sign-extend the immediate before comparing.
- R7: Fixed shifts SLL=10, SRL=11 and SRA=12 shift `src_b_i` by `shamt_i`, and `src_a_i` has no effect on their result.
- R8: Variable shifts SLLV=13, SRLV=14 and SRAV=15 shift `src_b_i` by `src_a_i[4:0]` only. Arithmetic right shifts fill with bit 31 of `src_b_i`; logical shifts fill with 0.
- R9: LUI=16 places `imm_i` in result bits 31:16 and zeros in bits 15:0.
- R10: CLZ=17 and CLO=18 return the number of leading 0 (1) bits of `src_a_i`, counted from bit 31, and 32 when the word is all zeros (all ones).
- R11: MOVZ=19 and MOVN=20 output `src_a_i` as the result. `wr_en_o` is 1 for MOVZ only when `src_b_i` is 0, and for MOVN only when `src_b_i` is non-zero.
- R12: `wr_en_o` is 1 for codes 0 to 18 and 21 to 27. Codes 28 to 31 are undefined and give result 0, `wr_en_o` 0 and `ovf_o` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| src_a_i | input | 32 | First register operand; also the variable shift distance and count source |
| src_b_i | input | 32 | Second register operand; shift source and move test operand |
| imm_i | input | 16 | Immediate field |
| shamt_i | input | 5 | Fixed shift distance |
| result_o | output | 32 | Registered result |
| ovf_o | output | 1 | Registered signed-overflow flag |
| wr_en_o | output | 1 | Registered write-enable |

## Verification
Every cycle, the assertions check the properties that hold whatever the operand values are. The overflow flag stays low outside the trapping forms. Comparisons yield a single bit. Upper-immediate loads leave the low half clear. Counts never exceed 32. Undefined codes stay quiet.

Only the bench's scenarios can show that the values themselves are right. That covers exact sums and overflow boundaries, shift fill with the sign bit, extension of the immediate, the all-zero and all-one counts, and the move conditions. It also covers the fact that the first operand has no effect on fixed shifts.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_ADDU  = 5'd1,
    OP_SUB   = 5'd2,
    OP_SUBU  = 5'd3,
    OP_AND   = 5'd4,
    OP_OR    = 5'd5,
    OP_XOR   = 5'd6,
    OP_NOR   = 5'd7,
    OP_SLT   = 5'd8,
    OP_SLTU  = 5'd9,
    OP_SLL   = 5'd10,
    OP_SRL   = 5'd11,
    OP_SRA   = 5'd12,
    OP_SLLV  = 5'd13,
    OP_SRLV  = 5'd14,
    OP_SRAV  = 5'd15,
    OP_LUI   = 5'd16,
    OP_CLZ   = 5'd17,
    OP_CLO   = 5'd18,
    OP_MOVZ  = 5'd19,
    OP_MOVN  = 5'd20,
    OP_ADDI  = 5'd21,
    OP_ADDIU = 5'd22,
    OP_SLTI  = 5'd23,
    OP_SLTIU = 5'd24,
    OP_ANDI  = 5'd25,
    OP_ORI   = 5'd26,
    OP_XORI  = 5'd27,
    OP_UNDEF = 5'd31
  } alu_op_e;

  typedef enum logic [1:0] {
    EXT_NONE = 2'd0,
    EXT_SIGN = 2'd1,
    EXT_ZERO = 2'd2
  } ext_mode_e;

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
  import alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  alu_op_e          op,
  input  logic [W-1:0]     reg_b,
  input  logic [IMM_W-1:0] imm,
  output logic [W-1:0]     opnd_b
);

  localparam int PAD = W - IMM_W;

  ext_mode_e mode;

  always_comb begin
    unique case (op)
      OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU: mode = EXT_SIGN;
      OP_ANDI, OP_ORI, OP_XORI:             mode = EXT_ZERO;
      default:                              mode = EXT_NONE;
    endcase
  end

  always_comb begin
    unique case (mode)
      EXT_SIGN: opnd_b = {{PAD{imm[IMM_W-1]}}, imm};
      EXT_ZERO: opnd_b = {{PAD{1'b0}}, imm};
      default:  opnd_b = reg_b;
    endcase
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W    = 32,
  parameter int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    din,
  input  logic [SH_W-1:0] amt,
  input  logic            left,
  input  logic            arith,
  output logic [W-1:0]    dout
);

  logic [W-1:0]         rev_in;
  logic [W-1:0]         rev_out;
  logic                 fill;
  logic [SH_W:0][W-1:0] stg;

  always_comb begin
    for (int i = 0; i < W; i++) rev_in[i] = din[W-1-i];
  end

  assign fill   = arith & ~left & din[W-1];
  assign stg[0] = left ? rev_in : din;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int D = 1 << k;
    assign stg[k+1] = amt[k] ? {{D{fill}}, stg[k][W-1:D]} : stg[k];
  end

  always_comb begin
    for (int i = 0; i < W; i++) rev_out[i] = stg[SH_W][W-1-i];
  end

  assign dout = left ? rev_out : stg[SH_W];

endmodule

// File: rtl/alu_lead_count.sv
module alu_lead_count #(
  parameter int W    = 32,
  parameter int CN_W = $clog2(W + 1)
) (
  input  logic [W-1:0]    din,
  output logic [CN_W-1:0] cnt
);

  always_comb begin
    logic hit;
    hit = 1'b0;
    cnt = CN_W'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit && din[i]) begin
        cnt = CN_W'(W - 1 - i);
        hit = 1'b1;
      end
    end
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [4:0]       op_i,
  input  logic [W-1:0]     src_a_i,
  input  logic [W-1:0]     src_b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [$clog2(W)-1:0] shamt_i,
  output logic [W-1:0]     result_o,
  output logic             ovf_o,
  output logic             wr_en_o
);

  localparam int SH_W = $clog2(W);
  localparam int CN_W = $clog2(W + 1);

  alu_op_e         op;
  alu_op_e         op_q;
  logic [W-1:0]    opnd_b;
  logic [W-1:0]    sum;
  logic [W-1:0]    diff;
  logic            add_ovf;
  logic            sub_ovf;
  logic [SH_W-1:0] sh_amt;
  logic            sh_left;
  logic            sh_arith;
  logic [W-1:0]    sh_out;
  logic [W-1:0]    cnt_src;
  logic [CN_W-1:0] cnt;
  logic [W-1:0]    res_d;
  logic            ovf_d;
  logic            wr_d;

  assign op = alu_op_e'(op_i);

  alu_operand_sel #(.W(W), .IMM_W(IMM_W)) u_opsel (
    .op     (op),
    .reg_b  (src_b_i),
    .imm    (imm_i),
    .opnd_b (opnd_b)
  );

  assign sum     = src_a_i + opnd_b;
  assign diff    = src_a_i - opnd_b;
  assign add_ovf = (src_a_i[W-1] == opnd_b[W-1]) && (sum[W-1] != src_a_i[W-1]);
  assign sub_ovf = (src_a_i[W-1] != opnd_b[W-1]) && (diff[W-1] != src_a_i[W-1]);

  assign sh_amt   = (op == OP_SLLV || op == OP_SRLV || op == OP_SRAV) ? src_a_i[SH_W-1:0] : shamt_i;
  assign sh_left  = (op == OP_SLL || op == OP_SLLV);
  assign sh_arith = (op == OP_SRA || op == OP_SRAV);

  alu_shifter #(.W(W), .SH_W(SH_W)) u_shift (
    .din   (src_b_i),
    .amt   (sh_amt),
    .left  (sh_left),
    .arith (sh_arith),
    .dout  (sh_out)
  );

  assign cnt_src = (op == OP_CLO) ? ~src_a_i : src_a_i;

  alu_lead_count #(.W(W), .CN_W(CN_W)) u_count (
    .din (cnt_src),
    .cnt (cnt)
  );

  always_comb begin
    res_d = '0;
    ovf_d = 1'b0;
    wr_d  = 1'b1;
    unique case (op)
      OP_ADD, OP_ADDI: begin
        res_d = sum;
        ovf_d = add_ovf;
      end
      OP_ADDU, OP_ADDIU: res_d = sum;
      OP_SUB: begin
        res_d = diff;
        ovf_d = sub_ovf;
      end
      OP_SUBU:           res_d = diff;
      OP_AND, OP_ANDI:   res_d = src_a_i & opnd_b;
      OP_OR, OP_ORI:     res_d = src_a_i | opnd_b;
      OP_XOR, OP_XORI:   res_d = src_a_i ^ opnd_b;
      OP_NOR:            res_d = ~(src_a_i | opnd_b);
      OP_SLT, OP_SLTI:   res_d = W'($signed(src_a_i) < $signed(opnd_b));
      OP_SLTU, OP_SLTIU: res_d = W'(src_a_i < opnd_b);
      OP_SLL, OP_SRL, OP_SRA, OP_SLLV, OP_SRLV, OP_SRAV: res_d = sh_out;
      OP_LUI:            res_d = {imm_i, {(W-IMM_W){1'b0}}};
      OP_CLZ, OP_CLO:    res_d = W'(cnt);
      OP_MOVZ: begin
        res_d = src_a_i;
        wr_d  = (src_b_i == '0);
      end
      OP_MOVN: begin
        res_d = src_a_i;
        wr_d  = (src_b_i != '0);
      end
      default:           wr_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      ovf_o    <= 1'b0;
      wr_en_o  <= 1'b0;
      op_q     <= OP_UNDEF;
    end else begin
      result_o <= res_d;
      ovf_o    <= ovf_d;
      wr_en_o  <= wr_d;
      op_q     <= op;
    end
  end

  // R4: only the trapping add/subtract forms may raise the flag
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    !(op_q inside {OP_ADD, OP_ADDI, OP_SUB}) |-> !ovf_o);

  // R6: comparisons produce 0 or 1
  a_r6_slt_boolean: assert property (@(posedge clk) disable iff (rst)
    (op_q inside {OP_SLT, OP_SLTU, OP_SLTI, OP_SLTIU}) |-> (result_o[W-1:1] == '0));

  // R9: upper-immediate load leaves the low half clear
  a_r9_lui_low_clear: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_LUI) |-> (result_o[W-IMM_W-1:0] == '0));

  // R10: leading-bit counts lie within 0..W
  a_r10_count_range: assert property (@(posedge clk) disable iff (rst)
    (op_q inside {OP_CLZ, OP_CLO}) |-> (result_o <= W));

  // R12: undefined codes leave every output low
  a_r12_undef_quiet: assert property (@(posedge clk) disable iff (rst)
    (5'(op_q) > 5'd27) |-> (result_o == '0 && !wr_en_o && !ovf_o));

endmodule

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_i = 5'd0;
  logic [31:0] src_a_i = '0;
  logic [31:0] src_b_i = '0;
  logic [15:0] imm_i = '0;
  logic [4:0]  shamt_i = '0;
  logic [31:0] result_o;
  logic        ovf_o;
  logic        wr_en_o;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  int_exec_unit u_int_exec_unit (
    .clk(clk), .rst(rst), .op_i(op_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
    .imm_i(imm_i), .shamt_i(shamt_i), .result_o(result_o), .ovf_o(ovf_o), .wr_en_o(wr_en_o)
  );

  function automatic string req_of(input logic [4:0] op);
    case (op)
      5'd0, 5'd1, 5'd21, 5'd22, 5'd2, 5'd3: return "R2/R3";
      5'd4, 5'd5, 5'd6, 5'd7, 5'd25, 5'd26, 5'd27: return "R5";
      5'd8, 5'd9, 5'd23, 5'd24: return "R6";
      5'd10, 5'd11, 5'd12: return "R7";
      5'd13, 5'd14, 5'd15: return "R8";
      5'd16: return "R9";
      5'd17, 5'd18: return "R10";
      5'd19, 5'd20: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [31:0] lead(input logic [31:0] x, input logic bitv);
    logic [31:0] n = 0;
    for (int i = 31; i >= 0; i--) begin
      if (x[i] != bitv) break;
      n++;
    end
    return n;
  endfunction

  // expected {wr, ovf, result}
  function automatic logic [33:0] model(input logic [4:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [15:0] im,
                                        input logic [4:0] sh);
    logic [31:0] se = {{16{im[15]}}, im};
    logic [31:0] ze = {16'h0, im};
    logic signed [32:0] wide;
    logic [31:0] r = 0;
    logic o = 0;
    logic w = 1;
    case (op)
      5'd0:  begin r = a + b;  wide = $signed({a[31], a}) + $signed({b[31], b});   o = (wide > 33'sd2147483647) || (wide < -33'sd2147483648); end
      5'd21: begin r = a + se; wide = $signed({a[31], a}) + $signed({se[31], se}); o = (wide > 33'sd2147483647) || (wide < -33'sd2147483648); end
      5'd2:  begin r = a - b;  wide = $signed({a[31], a}) - $signed({b[31], b});   o = (wide > 33'sd2147483647) || (wide < -33'sd2147483648); end
      5'd1:  r = a + b;
      5'd22: r = a + se;
      5'd3:  r = a - b;
      5'd4:  r = a & b;
      5'd5:  r = a | b;
      5'd6:  r = a ^ b;
      5'd7:  r = ~(a | b);
      5'd25: r = a & ze;
      5'd26: r = a | ze;
      5'd27: r = a ^ ze;
      5'd8:  r = {31'd0, $signed(a) < $signed(b)};
      5'd9:  r = {31'd0, a < b};
      5'd23: r = {31'd0, $signed(a) < $signed(se)};
      5'd24: r = {31'd0, a < se};
      5'd10: r = b << sh;
      5'd11: r = b >> sh;
      5'd12: r = 32'($signed(b) >>> sh);
      5'd13: r = b << a[4:0];
      5'd14: r = b >> a[4:0];
      5'd15: r = 32'($signed(b) >>> a[4:0]);
      5'd16: r = {im, 16'h0};
      5'd17: r = lead(a, 1'b0);
      5'd18: r = lead(a, 1'b1);
      5'd19: begin r = a; w = (b == 0); end
      5'd20: begin r = a; w = (b != 0); end
      default: begin r = 0; w = 0; end
    endcase
    return {w, o, r};
  endfunction

  task automatic check(input string tag, input logic [31:0] er, input logic eo, input logic ew);
    tests++;
    if (result_o !== er || ovf_o !== eo || wr_en_o !== ew) begin
      fails++;
      $display("FAIL %s op=%0d: got res=%h ovf=%0b wr=%0b, expected res=%h ovf=%0b wr=%0b",
               tag, op_i, result_o, ovf_o, wr_en_o, er, eo, ew);
    end
  endtask

  task automatic run(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic [15:0] im, input logic [4:0] sh);
    logic [33:0] e;
    op_i = op; src_a_i = a; src_b_i = b; imm_i = im; shamt_i = sh;
    e = model(op, a, b, im, sh);
    @(posedge clk); #2;
    check(req_of(op), e[31:0], e[32], e[33]);
  endtask

  function automatic logic [31:0] pick32();
    case ($urandom % 8)
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset holds outputs at zero even with an active operation applied
    op_i = 5'd5; src_a_i = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #2 check("R1", 32'h0, 1'b0, 1'b0);
    @(negedge clk) rst = 1'b0;
    #2;
    // R1: one-cycle latency, R2/R3 overflow boundaries
    run(5'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0);           // R3 ovf
    run(5'd1, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0);           // R4 none
    run(5'd2, 32'h8000_0000, 32'h1, 16'h0, 5'd0);           // R3 ovf
    run(5'd3, 32'h8000_0000, 32'h1, 16'h0, 5'd0);           // R4 none
    run(5'd2, 32'h0, 32'h8000_0000, 16'h0, 5'd0);           // R3 ovf
    run(5'd21, 32'h8000_0000, 32'h0, 16'hFFFF, 5'd0);       // R3 ovf via sign-extended -1
    run(5'd22, 32'h0000_0005, 32'h0, 16'hFFFF, 5'd0);       // R2 addiu sign extension
    run(5'd25, 32'hFFFF_FFFF, 32'h0, 16'h8001, 5'd0);       // R5 zero extension
    run(5'd7, 32'h0F0F_0000, 32'h0000_00F0, 16'h0, 5'd0);   // R5 nor
    run(5'd24, 32'h0000_0005, 32'h0, 16'hFFFF, 5'd0);       // R6 unsigned vs sign-extended
    run(5'd23, 32'h0000_0005, 32'h0, 16'hFFFF, 5'd0);       // R6 signed
    run(5'd8, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0);           // R6
    run(5'd12, 32'h1234_5678, 32'h8000_0000, 16'h0, 5'd31); // R8 fill with sign
    run(5'd12, 32'h0, 32'h8000_0000, 16'h0, 5'd31);         // R7 src_a has no effect
    run(5'd14, 32'hFFFF_FFE3, 32'h8000_0000, 16'h0, 5'd0);  // R8 low 5 bits: 3
    run(5'd13, 32'h0000_0021, 32'h0000_0001, 16'h0, 5'd9);  // R8 amount 1
    run(5'd16, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hBEEF, 5'd0); // R9
    run(5'd17, 32'h0, 32'h0, 16'h0, 5'd0);                  // R10 all zero -> 32
    run(5'd18, 32'hFFFF_FFFF, 32'h0, 16'h0, 5'd0);          // R10 all ones -> 32
    run(5'd17, 32'h0000_0001, 32'h0, 16'h0, 5'd0);          // R10 -> 31
    run(5'd18, 32'hFFFE_0000, 32'h0, 16'h0, 5'd0);          // R10 -> 15
    run(5'd19, 32'hCAFE_0001, 32'h0, 16'h0, 5'd0);          // R11 movz taken
    run(5'd20, 32'hCAFE_0001, 32'h0, 16'h0, 5'd0);          // R11 movn not taken
    run(5'd20, 32'hCAFE_0001, 32'h4, 16'h0, 5'd0);          // R11 movn taken
    run(5'd30, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd31); // R12
    // R1: reset mid-stream clears the registered outputs
    op_i = 5'd5; src_a_i = 32'h55AA_55AA; rst = 1'b1;
    @(posedge clk); #2 check("R1", 32'h0, 1'b0, 1'b0);
    rst = 1'b0;
    // random mix across all codes
    for (int n = 0; n < 4000; n++) begin
      run(5'($urandom % 32), pick32(), pick32(), 16'($urandom), 5'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule